// File: doc/BRIEF.md
# RNG Control, Status and Clock Monitor

This block holds the software-visible control and status of a random number generator peripheral. It has a single-cycle register port: a write lands on the next bus-clock edge, and a read returns data combinationally from the address. The control word turns the generator on, enables its interrupt, locks the configuration, and selects whether the RNG clock is checked. The status word shows the ready and error conditions that the noise source and conditioning stage report, plus two sticky error flags that software acknowledges.

A clock monitor checks the RNG clock against the bus clock. Each RNG clock edge passes through a synchronizer into the bus domain. A counter then measures the bus cycles between successive edges. When the gap exceeds 32 bus cycles, the RNG clock is slower than one thirty-second of the bus clock, and a clock error is raised. One interrupt line combines ready and the two sticky flags under the interrupt enable.

Top module: `rng_csr`

## Requirements
- R1: After reset, the control word (offset 0x0) and the status word (offset 0x4) both read 0, and `irq_o` is 0.
- R2: In the control word, bit 2 (generator on) and bit 3 (interrupt on) read back the value last written to them. Bit 30 (conditioning reset) is a request only and always reads 0. Every unassigned bit reads 0.
- R3: Control bit 31 (lock) is set by writing 1 to it. Writing 0 does not clear it; only reset does.
- R4: Control bit 5 (detection off: 1 turns clock checking off, 0 turns it on) changes only on a control write that has bit 30 set, while the stored lock is 0 and the stored generator-on bit is 0. On any other write it keeps its value.
- R5: Status bit 0 (ready) equals the data-ready input ANDed with generator-on. Status bit 2 (seed error now) is the seed-error input, delayed by one bus-clock register stage.
- R6: `irq_o` is 1 exactly when interrupt-on is 1 and at least one of status bits 0, 5 or 6 is 1.
- R7: Status bit 1 (clock error now) applies while the generator is on and detection is on. It becomes 1 when more than 32 bus cycles pass between synchronized RNG rising edges. It stays 0 when the RNG period is 32 bus cycles or less. Once set, it clears after one edge-to-edge gap of 32 cycles or fewer.
- R8: Status bit 5 (clock error flag) becomes 1 on the same edge that bit 1 rises. Status bit 6 (seed error flag) becomes 1 on the same edge that bit 2 rises.
- R9: Each flag clears only on a status write that carries 0 at its bit. Writing 1 leaves it unchanged. A new rising error in the same cycle as a clearing write leaves the flag set.
- R10: While detection is off, or while the generator is off, status bit 1 stays 0 and bit 5 is not set by a slow or stopped RNG clock.
- R11: Status writes have no effect on bits 0, 1 and 2.
- R12: Reads at any offset other than 0x0 and 0x4 return 0, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rng_clk_i | input | 1 | RNG clock, asynchronous to `clk_i` |
| addr_i | input | ADDR_W | Register byte offset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| data_ready_i | input | 1 | Random word available, from the conditioning stage |
| seed_err_i | input | 1 | Faulty noise sequence seen, from the noise source |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest condition to reach from the ports is the clock-error boundary: a gap of exactly 32 bus cycles must pass, and a gap of 33 must fail. This depends on how the asynchronous RNG clock lands against the synchronizer. The bench runs the RNG clock as a whole multiple of the bus period, with a fixed sub-cycle phase offset, so the synchronized edge spacing is exactly that multiple. It then sweeps the multiple across the threshold. Before each period setting it turns the generator off and on again, so the monitor starts from a clean state. It then stops the RNG clock entirely and brings a fast clock back, to cover setting and clearing.

// File: rtl/rng_csr_pkg.sv
package rng_csr_pkg;

    localparam int unsigned CTRL_OFS = 0;
    localparam int unsigned STAT_OFS = 4;

    // control word bit positions
    localparam int unsigned EN_BIT     = 2;
    localparam int unsigned IE_BIT     = 3;
    localparam int unsigned DETOFF_BIT = 5;
    localparam int unsigned CRST_BIT   = 30;
    localparam int unsigned LOCK_BIT   = 31;

    // status word bit positions
    localparam int unsigned RDY_BIT  = 0;
    localparam int unsigned CERR_BIT = 1;
    localparam int unsigned SERR_BIT = 2;
    localparam int unsigned CFLG_BIT = 5;
    localparam int unsigned SFLG_BIT = 6;

    typedef struct packed {
        logic lock;
        logic det_off;
        logic ie;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic sflg;
        logic cflg;
        logic serr;
        logic cerr;
    } flags_t;

endpackage

// File: rtl/rng_edge_sync.sv
module rng_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    localparam int unsigned W = STAGES + 1;

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[W-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign rise_o = sh_q[W-2] & ~sh_q[W-1];

endmodule

// File: rtl/rng_clk_mon.sv
module rng_clk_mon #(
    parameter int unsigned LIMIT = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic rise_i,
    output logic slow_o
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             slow;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d = mon_q;
        if (!en_i) begin
            mon_d = '0;
        end else if (rise_i) begin
            mon_d.cnt = '0;
            if (mon_q.cnt < LIM) mon_d.slow = 1'b0;
        end else if (mon_q.cnt != LIM) begin
            mon_d.cnt = mon_q.cnt + 1'b1;
            if (mon_d.cnt == LIM) mon_d.slow = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mon_q <= '0;
        else         mon_q <= mon_d;
    end

    assign slow_o = mon_q.slow;

endmodule

// File: rtl/rng_csr_regs.sv
module rng_csr_regs
    import rng_csr_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              data_ready_i,
    input  logic              seed_err_i,
    input  logic              slow_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              mon_en_o,
    output ctrl_t             ctl_o,
    output flags_t            flg_o
);
    typedef struct packed {
        ctrl_t  ctl;
        flags_t flg;
    } regs_t;

    regs_t r_d, r_q;
    logic  ctl_sel, stat_sel, rdy;

    assign ctl_sel  = (addr_i == ADDR_W'(CTRL_OFS));
    assign stat_sel = (addr_i == ADDR_W'(STAT_OFS));
    assign rdy      = data_ready_i & r_q.ctl.en;

    always_comb begin
        r_d = r_q;
        if (wr_en_i && ctl_sel) begin
            r_d.ctl.en = wdata_i[EN_BIT];
            r_d.ctl.ie = wdata_i[IE_BIT];
            if (wdata_i[LOCK_BIT]) r_d.ctl.lock = 1'b1;
            if (wdata_i[CRST_BIT] && !r_q.ctl.lock && !r_q.ctl.en)
                r_d.ctl.det_off = wdata_i[DETOFF_BIT];
        end
        if (wr_en_i && stat_sel) begin
            if (!wdata_i[CFLG_BIT]) r_d.flg.cflg = 1'b0;
            if (!wdata_i[SFLG_BIT]) r_d.flg.sflg = 1'b0;
        end
        r_d.flg.cerr = slow_i & r_q.ctl.en & ~r_q.ctl.det_off;
        r_d.flg.serr = seed_err_i;
        if (r_d.flg.cerr && !r_q.flg.cerr) r_d.flg.cflg = 1'b1;
        if (r_d.flg.serr && !r_q.flg.serr) r_d.flg.sflg = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        if (ctl_sel) begin
            rdata_o[EN_BIT]     = r_q.ctl.en;
            rdata_o[IE_BIT]     = r_q.ctl.ie;
            rdata_o[DETOFF_BIT] = r_q.ctl.det_off;
            rdata_o[LOCK_BIT]   = r_q.ctl.lock;
        end else if (stat_sel) begin
            rdata_o[RDY_BIT]  = rdy;
            rdata_o[CERR_BIT] = r_q.flg.cerr;
            rdata_o[SERR_BIT] = r_q.flg.serr;
            rdata_o[CFLG_BIT] = r_q.flg.cflg;
            rdata_o[SFLG_BIT] = r_q.flg.sflg;
        end
    end

    assign irq_o    = r_q.ctl.ie & (rdy | r_q.flg.cflg | r_q.flg.sflg);
    assign mon_en_o = r_q.ctl.en & ~r_q.ctl.det_off;
    assign ctl_o    = r_q.ctl;
    assign flg_o    = r_q.flg;

endmodule

// File: rtl/rng_csr.sv
module rng_csr
    import rng_csr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SLOW_LIMIT  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rng_clk_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic              data_ready_i,
    input  logic              seed_err_i,
    output logic              irq_o
);
    logic   rng_rise, slow, mon_en;
    ctrl_t  ctl_w;
    flags_t flg_w;

    rng_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(rng_clk_i),
        .rise_o (rng_rise)
    );

    rng_clk_mon #(.LIMIT(SLOW_LIMIT)) i_mon (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (mon_en),
        .rise_i(rng_rise),
        .slow_o(slow)
    );

    rng_csr_regs #(.ADDR_W(ADDR_W), .DATA_W(32)) i_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .addr_i      (addr_i),
        .wr_en_i     (wr_en_i),
        .wdata_i     (wdata_i),
        .data_ready_i(data_ready_i),
        .seed_err_i  (seed_err_i),
        .slow_i      (slow),
        .rdata_o     (rdata_o),
        .irq_o       (irq_o),
        .mon_en_o    (mon_en),
        .ctl_o       (ctl_w),
        .flg_o       (flg_w)
    );

endmodule

// File: rtl/rng_csr_chk.sv
module rng_csr_chk
    import rng_csr_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [31:0]       wdata_i,
    input logic              irq_o,
    input ctrl_t             ctl,
    input flags_t            flg
);
    // R3
    lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl.lock |=> ctl.lock);

    // R4
    detoff_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ctl.det_off) |-> $past(wr_en_i && addr_i == ADDR_W'(CTRL_OFS)
            && wdata_i[CRST_BIT] && !ctl.lock && !ctl.en));

    // R6
    irq_needs_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ctl.ie);

    // R8
    cflg_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flg.cerr) |-> flg.cflg);

    // R8
    sflg_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flg.serr) |-> flg.sflg);

    // R9
    cflg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flg.cflg && !(wr_en_i && addr_i == ADDR_W'(STAT_OFS) && !wdata_i[CFLG_BIT]))
            |=> flg.cflg);

    // R10
    cerr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl.det_off || !ctl.en) |=> !flg.cerr);

endmodule

bind rng_csr rng_csr_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .wr_en_i(wr_en_i),
    .wdata_i(wdata_i),
    .irq_o  (irq_o),
    .ctl    (ctl_w),
    .flg    (flg_w)
);

// File: tb/test_rng_csr.sv
module test_rng_csr;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;

    logic        clk = 1'b0, rst_n = 1'b0, rng_clk = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0, rdata;
    logic        drdy = 1'b0, serr = 1'b0, irq;

    int n_chk = 0, n_fail = 0;
    int rng_mult = 8;
    bit rng_run = 1'b1;
    bit done = 1'b0;

    rng_csr i_rng_csr (
        .clk_i(clk), .rst_ni(rst_n), .rng_clk_i(rng_clk),
        .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata),
        .data_ready_i(drdy), .seed_err_i(serr), .irq_o(irq)
    );

    always #(HALF) clk = ~clk;

    // RNG clock: toggles off the bus edges by 3 time units
    initial begin
        #3;
        forever begin
            if (rng_run) rng_clk = ~rng_clk;
            #(rng_mult * HALF);
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, v); check("R1 ctrl", v, 32'h0);
        rd(4'h4, v); check("R1 status", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 readback of on / irq-on bits, request bit reads 0
        wr(4'h0, 32'h0000_000C); rd(4'h0, v); check("R2 en+ie", v, 32'h0000_000C);
        wr(4'h0, 32'h0F00_0008); rd(4'h0, v); check("R2 ie only", v, 32'h0000_0008);
        wr(4'h0, 32'h0000_0000);

        // R4 detection-off gating
        wr(4'h0, 32'h0000_0020); rd(4'h0, v); check("R4 no request", v, 32'h0);
        wr(4'h0, 32'h4000_0020); rd(4'h0, v); check("R4 accepted", v, 32'h0000_0020);
        rd(4'h0, v); check("R2 request reads 0", {31'b0, v[30]}, 32'h0);
        wr(4'h0, 32'h0000_0004); rd(4'h0, v); check("R4 keep on en write", v, 32'h0000_0024);
        wr(4'h0, 32'h4000_0004); rd(4'h0, v); check("R4 blocked while on", v, 32'h0000_0024);

        // R10 detection off: slow clock raises nothing
        rng_mult = 44; idle(200);
        rd(4'h4, v); check("R10 det off cerr/cflg", v & 32'h22, 32'h0);
        wr(4'h0, 32'h0000_0000);
        wr(4'h0, 32'h4000_0000); rd(4'h0, v); check("R4 re-enable detection", v, 32'h0);

        // R7/R8 threshold sweep around 32 bus cycles
        for (int p = 24; p <= 40; p++) begin
            wr(4'h0, 32'h0);
            rng_mult = p;
            wr(4'h4, 32'h0);
            wr(4'h0, 32'h4);
            idle(4 * p + 20);
            rd(4'h4, v);
            check($sformatf("R7 cerr period %0d", p), {31'b0, v[1]}, {31'b0, (p > 32)});
            check($sformatf("R8 cflg period %0d", p), {31'b0, v[5]}, {31'b0, (p > 32)});
        end

        // R10 generator off: no clock error
        wr(4'h0, 32'h0); wr(4'h4, 32'h0); idle(200);
        rd(4'h4, v); check("R10 gen off", v & 32'h22, 32'h0);

        // R7 stopped clock then recovery
        rng_mult = 8; wr(4'h0, 32'h4); idle(40);
        rd(4'h4, v); check("R7 fast ok", {31'b0, v[1]}, 32'h0);
        rng_run = 1'b0; idle(60);
        rd(4'h4, v); check("R7 stopped", v & 32'h22, 32'h22);
        rng_run = 1'b1; idle(60);
        rd(4'h4, v); check("R7 recovered, R9 flag held", v & 32'h22, 32'h20);

        // R9 write 1 keeps, write 0 clears; R6 irq from flag
        wr(4'h0, 32'hC); idle(1);
        check("R6 irq from cflg", {31'b0, irq}, 32'h1);
        wr(4'h4, 32'h0000_0020); rd(4'h4, v); check("R9 write1 keeps", {31'b0, v[5]}, 32'h1);
        wr(4'h4, 32'h0); rd(4'h4, v); check("R9 write0 clears", {31'b0, v[5]}, 32'h0);
        check("R6 irq low", {31'b0, irq}, 32'h0);

        // R5/R6 data ready
        @(negedge clk) drdy = 1'b1;
        rd(4'h4, v); check("R5 ready", {31'b0, v[0]}, 32'h1);
        check("R6 irq ready", {31'b0, irq}, 32'h1);
        wr(4'h0, 32'h4); idle(1); check("R6 irq masked", {31'b0, irq}, 32'h0);
        // R11 status writes leave bits 0..2
        wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, v); check("R11 ones", v, 32'h1);
        wr(4'h4, 32'h0); rd(4'h4, v); check("R11 zeros", v, 32'h1);
        wr(4'h0, 32'h8); rd(4'h4, v); check("R5 ready gated", {31'b0, v[0]}, 32'h0);
        check("R6 irq none", {31'b0, irq}, 32'h0);
        @(negedge clk) drdy = 1'b0;

        // R5/R8 seed error
        @(negedge clk) serr = 1'b1;
        rd(4'h4, v); check("R8 seed same edge", v & 32'h44, 32'h44);
        check("R6 irq seed", {31'b0, irq}, 32'h1);
        wr(4'h4, 32'h40); rd(4'h4, v); check("R9 seed write1", v & 32'h44, 32'h44);
        wr(4'h4, 32'h0); rd(4'h4, v); check("R9 seed cleared", v & 32'h44, 32'h04);
        @(negedge clk) serr = 1'b0;
        idle(2);
        // R9 rising error beats clear in same cycle
        @(negedge clk);
        serr = 1'b1; addr = 4'h4; wdata = 32'h0; wr_en = 1'b1;
        @(negedge clk) wr_en = 1'b0;
        rd(4'h4, v); check("R9 set wins", {31'b0, v[6]}, 32'h1);
        serr = 1'b0; wr(4'h4, 32'h0);

        // R12 other offset
        wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, v); check("R12 read other", v, 32'h0);
        rd(4'h0, v); check("R12 ctrl untouched", v, 32'h8);

        // R3 lock
        wr(4'h0, 32'h8000_0000); rd(4'h0, v); check("R3 lock set", v, 32'h8000_0000);
        wr(4'h0, 32'h4000_0020); rd(4'h0, v); check("R4 locked", v, 32'h8000_0000);
        wr(4'h0, 32'h0); rd(4'h0, v); check("R3 lock sticks", v, 32'h8000_0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule